// File: doc/BRIEF.md
# Circular Return Address Stack

This block holds the return addresses of a 13-bit program counter. The sequencer saves the current PC value on every subroutine call and on every branch that an interrupt forces. It restores that value on each of the three return kinds: plain return, return with a literal, and return from interrupt. Each entry stores every PC bit. A return therefore restores the whole address, and the page-select state does not need to be set up again.

The storage is a ring of eight entries. A write pointer moves through it modulo the depth. The pointer has no port, so nothing outside the block can read or load it. The block raises no overflow or underflow indication. A ninth nested save overwrites the oldest entry. A pop on an empty stack steps the pointer back around the ring and returns whatever that entry holds. The block has no connection to the upper-PC holding latch, so neither a push nor a pop can change that latch.

Top module: `ret_addr_stack`

## Requirements
- R1: An active-low reset returns the pointer to slot 0 and leaves the entry contents as they were. The first pop after reset, with no push before it, therefore presents slot 7.
- R2: A push writes `push_pc_i` into the slot the pointer selects and advances the pointer. From the next cycle on, `tos_o` equals the pushed value.
- R3: A pop moves the pointer back by one. Pops return the pushed values in last-in, first-out order, to a nesting depth of eight.
- R4: The ninth push with no pop in between overwrites the entry of the first push, and the tenth overwrites the second. The ring keeps the eight newest values.
- R5: A pop on an empty stack moves the pointer from 0 to 7 with no error indication, and `tos_o` then shows the entry in slot 6.
- R6: All 13 bits of an entry come back unchanged. This holds for all-ones, all-zeros and alternating bit patterns.
- R7: A push and a pop in the same cycle are illegal. The sequencer must never request both.
- R8: In a cycle with neither push nor pop, `tos_o` and the pointer hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Save `push_pc_i` (call or interrupt branch) |
| push_pc_i | input | 13 | PC value to save |
| pop_i | input | 1 | Return strobe (any of the three return kinds) |
| tos_o | output | 13 | Entry at the top of the stack |

## Verification
The bench fills the ring, drains it partly and then resets it. It then pops with no push first and expects slot 7. A design that cleared the entries, or that left the pointer where it was, returns a different value. A burst of ten pushes, popped ten times, checks that the two oldest values have been overwritten and that the pops wrap past slot 0. A design that saturated at full or empty would repeat one entry instead of cycling through the ring. Bit patterns of all-ones, alternating bits and zero find a truncated or swapped PC field. Idle gaps between operations find a top-of-stack output that drifts without a strobe.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_BOTH = 2'b11
  } ras_op_e;

  function automatic ras_op_e ras_decode(input logic push, input logic pop);
    return ras_op_e'({pop, push});
  endfunction
endpackage

// File: rtl/ras_ptr.sv
module ras_ptr
  import ras_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ras_op_e       op_i,
  output logic [PW-1:0] wr_idx_o,
  output logic [PW-1:0] rd_idx_o
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [PW-1:0] sp_q, sp_inc, sp_dec;

  // explicit wrap so non power-of-two depths still form a ring
  assign sp_inc = (sp_q == LAST) ? '0 : sp_q + 1'b1;
  assign sp_dec = (sp_q == '0) ? LAST : sp_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sp_q <= '0;
    else begin
      unique case (op_i)
        OP_PUSH: sp_q <= sp_inc;
        OP_POP:  sp_q <= sp_dec;
        default: sp_q <= sp_q;
      endcase
    end
  end

  assign wr_idx_o = sp_q;
  assign rd_idx_o = sp_dec;
endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter int PC_W  = 13,
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic            clk_i,
  input  logic            we_i,
  input  logic [PW-1:0]   wr_idx_i,
  input  logic [PC_W-1:0] wr_data_i,
  input  logic [PW-1:0]   rd_idx_i,
  output logic [PC_W-1:0] rd_data_o
);
  logic [PC_W-1:0] ent_q [DEPTH];

  // entries carry no reset: contents survive reset by design
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i) begin
      if (we_i && (wr_idx_i == PW'(g))) ent_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = ent_q[rd_idx_i];
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import ras_pkg::*;
#(
  parameter int PC_W  = 13,
  parameter int DEPTH = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [PC_W-1:0] push_pc_i,
  input  logic            pop_i,
  output logic [PC_W-1:0] tos_o
);
  localparam int PW = $clog2(DEPTH);

  ras_op_e       op;
  logic [PW-1:0] wr_idx, rd_idx;

  assign op = ras_decode(push_i, pop_i);

  ras_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op),
    .wr_idx_o (wr_idx),
    .rd_idx_o (rd_idx)
  );

  ras_store #(.PC_W(PC_W), .DEPTH(DEPTH)) u_store (
    .clk_i     (clk_i),
    .we_i      (op == OP_PUSH),
    .wr_idx_i  (wr_idx),
    .wr_data_i (push_pc_i),
    .rd_idx_i  (rd_idx),
    .rd_data_o (tos_o)
  );
endmodule

// File: rtl/ras_chk.sv
module ras_chk #(
  parameter int PC_W = 13,
  parameter int PW   = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            push_i,
  input logic            pop_i,
  input logic [PC_W-1:0] push_pc_i,
  input logic [PC_W-1:0] tos_o,
  input logic [PW-1:0]   sp_i
);
  p_push_tos_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |=> (tos_o == $past(push_pc_i)));

  p_push_adv_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |=> (sp_i == PW'($past(sp_i) + 1'b1)));

  p_pop_back_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> (sp_i == PW'($past(sp_i) - 1'b1)));

  p_lifo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) ##1 (pop_i && !push_i) |=> (tos_o == $past(tos_o, 2)));

  p_no_both_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i));

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !pop_i) |=> ($stable(tos_o) && $stable(sp_i)));
endmodule

bind ret_addr_stack ras_chk #(.PC_W(PC_W), .PW(PW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .push_i    (push_i),
  .pop_i     (pop_i),
  .push_pc_i (push_pc_i),
  .tos_o     (tos_o),
  .sp_i      (wr_idx)
);

// File: tb/tb_ret_addr_stack.sv
`timescale 1ns/1ps
module tb_ret_addr_stack;
  localparam int PC_W = 13;
  localparam int DEPTH = 8;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            push_i = 1'b0;
  logic            pop_i = 1'b0;
  logic [PC_W-1:0] push_pc_i = '0;
  logic [PC_W-1:0] tos_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [PC_W-1:0] mdl [DEPTH];
  int mptr = 0;

  logic [PC_W-1:0] exp_q [$];
  string           tag_q [$];

  always #2.5 clk_i = ~clk_i;

  ret_addr_stack #(.PC_W(PC_W), .DEPTH(DEPTH)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push_i),
    .push_pc_i(push_pc_i), .pop_i(pop_i), .tos_o(tos_o)
  );

  task automatic check(input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: tos_o=%h expected %h", req, act, exp);
    end
  endtask

  // monitor: while a pop strobe is held, the top entry must match the scoreboard
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      if (pop_i && rst_ni) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL scoreboard: pop with empty queue, tos_o=%h expected none", tos_o);
        end else begin
          check(tos_o, exp_q.pop_front(), tag_q.pop_front());
        end
      end
    end
  end

  task automatic do_push(input logic [PC_W-1:0] v, input string req);
    @(negedge clk_i);
    push_i = 1'b1; pop_i = 1'b0; push_pc_i = v;
    mdl[mptr] = v;
    mptr = (mptr + 1) % DEPTH;
    @(negedge clk_i);
    push_i = 1'b0;
    #1 check(tos_o, v, req);
  endtask

  task automatic do_pop(input string req);
    @(negedge clk_i);
    mptr = (mptr + DEPTH - 1) % DEPTH;
    exp_q.push_back(mdl[mptr]);
    tag_q.push_back(req);
    pop_i = 1'b1; push_i = 1'b0;
    @(negedge clk_i);
    pop_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    mptr = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, finished=0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [PC_W-1:0] held;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R2 R6: pushes with distinct bit patterns
    do_push(13'h1FFF, "R6");
    do_push(13'h1555, "R6");
    do_push(13'h0AAA, "R2");
    do_push(13'h0000, "R6");
    // R8: idle cycles leave tos_o alone
    held = tos_o;
    repeat (4) @(negedge clk_i);
    #1 check(tos_o, held, "R8");
    // R3 R6: LIFO pops
    repeat (4) do_pop("R3");

    // R4: ten pushes into an eight-entry ring, then ten pops (wraps too)
    do_reset();
    for (int i = 0; i < 10; i++) do_push(PC_W'(13'h0100 + i * 13'h0111), "R2");
    for (int i = 0; i < 10; i++) do_pop("R4");

    // R5: pop past empty wraps pointer 0 -> 7 and shows slot 6
    do_reset();
    do_push(13'h0123, "R2");
    do_pop("R3");
    do_pop("R5");
    @(negedge clk_i);
    #1 check(tos_o, mdl[6], "R5");

    // R1: fill, drain partly, reset, pop without pushing -> slot 7
    do_reset();
    for (int i = 0; i < 8; i++) do_push(PC_W'(13'h1000 + i * 13'h0021), "R2");
    repeat (3) do_pop("R3");
    do_reset();
    do_pop("R1");
    do_pop("R1");

    repeat (3) @(negedge clk_i);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: %0d pops unchecked, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule